// File: doc/BRIEF.md
# Guarded SPI Command Writer

This block is an SPI master that pushes a command packet into a peripheral whose receive buffer is small. Before any payload leaves, it holds chip select low and clocks a fixed five-byte header. The master sends one command byte followed by four zero bytes. At the same time it collects the peripheral's answer. The first answer byte must carry the ready code. The second answer byte gives the free space in the peripheral's write buffer. Only when the peripheral is ready and the space covers the whole packet does the block go on. It then streams two caller-supplied segments, first segment A and then segment B, inside the same chip-select window. If either condition fails, it releases the bus at once and reports an error code.

The caller places a request with a one-cycle start pulse and two 8-bit segment lengths. Payload bytes are fetched through one read strobe and index per segment, and the data must be valid in the same cycle. An optional workaround mode helps peripherals that sample their interrupt line to wake up. In this mode the block first drives the shared interrupt line high and waits a configurable minimum time before it lowers chip select. It hands the line back as soon as the header is done. Peripheral interrupts are masked for the whole transaction. The end of the transaction is signalled by a one-cycle done pulse together with a 2-bit status.

Top module: `spi_gated_writer`

## Requirements
- R1: SPI runs in mode 0 (SCLK idles low, MOSI changes after the falling edge, MISO is sampled on the rising edge), bytes go MSB first, and every transaction starts with five header bytes on MOSI: 0x0A, 0x00, 0x00, 0x00, 0x00.
- R2: If the first byte received during the header is not 0x02, the block ends with status 2'b01, fetches no payload and clocks no byte beyond the five header bytes.
- R3: If the second header byte received is less than len_a_i + len_b_i (a 9-bit sum, no wrap), the block ends with status 2'b10 and sends no payload.
- R4: On success (status 2'b00) the block fetches and sends segment A bytes at index 0..len_a_i-1 and then segment B bytes at index 0..len_b_i-1, in index order, all inside one chip-select low window.
- R5: A segment with length 0 is skipped entirely: its read strobe never asserts and it adds no bytes.
- R6: With irq_fix_i high at start, irq_oe_o and irq_do_o go high while chip select is still high, and chip select falls no earlier than the workaround wait (the number of clock cycles for 112 µs at the given clock rate) after irq_oe_o rises.
- R7: In workaround mode irq_oe_o drops once the fifth header byte completes, before the first SCLK rising edge of any payload byte. Without the mode irq_oe_o never rises.
- R8: Chip select is released at the end of every transaction, whatever the outcome. done_o is then a one-cycle pulse seen with cs_no high, and status_o holds 00 ok, 01 not ready or 10 no space.
- R9: irq_mask_o is high for the whole time cs_no is low and is low again by the cycle of done_o.
- R10: A start_i pulse that arrives while a transaction is in progress is ignored: there is no second chip-select window and no second done pulse.
- R11: There are at least CLK_DIV clock cycles between chip select falling and the first SCLK rising edge, and between the last SCLK falling edge and chip select rising. SCLK never toggles while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse, accepted only when idle |
| irq_fix_i | input | 1 | Enables interrupt-line workaround for this request |
| len_a_i | input | 8 | Byte count of segment A |
| len_b_i | input | 8 | Byte count of segment B |
| a_rd_o | output | 1 | Segment A fetch strobe |
| a_idx_o | output | 8 | Segment A byte index |
| a_data_i | input | 8 | Segment A byte, valid while a_rd_o is high |
| b_rd_o | output | 1 | Segment B fetch strobe |
| b_idx_o | output | 8 | Segment B byte index |
| b_data_i | input | 8 | Segment B byte, valid while b_rd_o is high |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to peripheral |
| miso_i | input | 1 | SPI data from peripheral |
| cs_no | output | 1 | SPI chip select, active low |
| irq_oe_o | output | 1 | Output enable for the shared interrupt line |
| irq_do_o | output | 1 | Drive value for the shared interrupt line |
| irq_mask_o | output | 1 | Masks peripheral interrupts during a transaction |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| status_o | output | 2 | Result code, valid with done_o |

## Verification
A wrong decision after the header shows up at the ports within one byte time. Fetch strobes then appear for an error outcome, or chip select rises early on success, and the byte count on MOSI comes out wrong. An error in the segment counter shows up as a fetch index out of order or as a wrong payload length. A sequencer stuck in a wait state shows up as a missing done pulse. A wrong interrupt-line hand-back shows up as irq_oe_o still high at the first payload edge. The bench reads each of these directly from the SPI pins, the fetch strobes and the cycle stamps of the chip-select, SCLK and interrupt-line edges.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned HDR_BYTES = 5;
  localparam logic [7:0]  HDR_CMD   = 8'h0A;
  localparam logic [7:0]  HDR_READY = 8'h02;

  typedef enum logic [1:0] {
    ST_OK        = 2'b00,
    ST_NOT_READY = 2'b01,
    ST_NO_SPACE  = 2'b10
  } sgw_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_IRQ_WAIT, S_CS_LEAD, S_LOAD, S_XFER, S_CS_TRAIL, S_DONE
  } sgw_state_e;

  typedef enum logic [1:0] {
    PH_HDR, PH_SEG_A, PH_SEG_B
  } sgw_phase_e;
endpackage

// File: rtl/sgw_byte_shift.sv
// Mode-0 byte engine: DIV clocks per SCLK half-period, MSB first.
module sgw_byte_shift #(
  parameter int unsigned DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int unsigned DW = $clog2(DIV + 1);

  logic          active_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic [7:0]    rx_q;
  logic          sclk_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          sh_q     <= tx_i;
          div_q    <= DW'(DIV - 1);
          bit_q    <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (div_q != '0) begin
        div_q <= div_q - 1'b1;
      end else begin
        div_q <= DW'(DIV - 1);
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = sh_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;
endmodule

// File: rtl/sgw_wait_timer.sv
// Down-counter; zero_o high once the loaded count has elapsed.
module sgw_wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spi_gated_writer.sv
module spi_gated_writer
  import sgw_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 48000,
  parameter int unsigned MIN_WAIT_US = 112,
  parameter int unsigned CLK_DIV     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       irq_fix_i,
  input  logic [7:0] len_a_i,
  input  logic [7:0] len_b_i,
  output logic       a_rd_o,
  output logic [7:0] a_idx_o,
  input  logic [7:0] a_data_i,
  output logic       b_rd_o,
  output logic [7:0] b_idx_o,
  input  logic [7:0] b_data_i,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic       cs_no,
  output logic       irq_oe_o,
  output logic       irq_do_o,
  output logic       irq_mask_o,
  output logic       done_o,
  output logic [1:0] status_o
);
  localparam int unsigned WAIT_CYC = (CLK_KHZ * MIN_WAIT_US + 999) / 1000;
  localparam int unsigned TMR_MAX  = (WAIT_CYC > CLK_DIV) ? WAIT_CYC : CLK_DIV;
  localparam int unsigned TW       = $clog2(TMR_MAX + 1);

  sgw_state_e  state_q;
  sgw_phase_e  phase_q, nx_phase;
  sgw_status_e status_q, nx_status;
  logic [7:0]  cnt_q, nx_cnt;
  logic [7:0]  len_a_q, len_b_q, hdr0_q, hdr1_q;
  logic        cs_n_q, irq_oe_q, irq_do_q, mask_q, done_q;
  logic        nx_trail;
  logic [8:0]  need;

  logic          go, byte_done;
  logic [7:0]    tx_byte, rx_byte;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  assign need = {1'b0, len_a_q} + {1'b0, len_b_q};

  // Next step after the current byte completes
  always_comb begin
    nx_trail  = 1'b0;
    nx_phase  = phase_q;
    nx_cnt    = cnt_q + 8'd1;
    nx_status = ST_OK;
    unique case (phase_q)
      PH_HDR: begin
        if (cnt_q == 8'(HDR_BYTES - 1)) begin
          nx_cnt = '0;
          if (hdr0_q != HDR_READY) begin
            nx_trail  = 1'b1;
            nx_status = ST_NOT_READY;
          end else if ({1'b0, hdr1_q} < need) begin
            nx_trail  = 1'b1;
            nx_status = ST_NO_SPACE;
          end else if (len_a_q != '0) begin
            nx_phase = PH_SEG_A;
          end else if (len_b_q != '0) begin
            nx_phase = PH_SEG_B;
          end else begin
            nx_trail = 1'b1;
          end
        end
      end
      PH_SEG_A: begin
        if ({1'b0, cnt_q} + 9'd1 == {1'b0, len_a_q}) begin
          nx_cnt = '0;
          if (len_b_q != '0) nx_phase = PH_SEG_B;
          else               nx_trail = 1'b1;
        end
      end
      PH_SEG_B: begin
        if ({1'b0, cnt_q} + 9'd1 == {1'b0, len_b_q}) nx_trail = 1'b1;
      end
      default: nx_trail = 1'b1;
    endcase
  end

  always_comb begin
    go      = (state_q == S_LOAD);
    a_rd_o  = go && (phase_q == PH_SEG_A);
    b_rd_o  = go && (phase_q == PH_SEG_B);
    unique case (phase_q)
      PH_SEG_A: tx_byte = a_data_i;
      PH_SEG_B: tx_byte = b_data_i;
      default:  tx_byte = (cnt_q == '0) ? HDR_CMD : 8'h00;
    endcase
    tmr_load = ((state_q == S_IDLE) && start_i)
            || ((state_q == S_IRQ_WAIT) && tmr_zero)
            || ((state_q == S_XFER) && byte_done && nx_trail);
    tmr_val  = ((state_q == S_IDLE) && irq_fix_i) ? TW'(WAIT_CYC) : TW'(CLK_DIV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      phase_q  <= PH_HDR;
      status_q <= ST_OK;
      cnt_q    <= '0;
      len_a_q  <= '0;
      len_b_q  <= '0;
      hdr0_q   <= '0;
      hdr1_q   <= '0;
      cs_n_q   <= 1'b1;
      irq_oe_q <= 1'b0;
      irq_do_q <= 1'b0;
      mask_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          len_a_q <= len_a_i;
          len_b_q <= len_b_i;
          phase_q <= PH_HDR;
          cnt_q   <= '0;
          mask_q  <= 1'b1;
          if (irq_fix_i) begin
            irq_oe_q <= 1'b1;
            irq_do_q <= 1'b1;
            state_q  <= S_IRQ_WAIT;
          end else begin
            cs_n_q  <= 1'b0;
            state_q <= S_CS_LEAD;
          end
        end
        S_IRQ_WAIT: if (tmr_zero) begin
          cs_n_q  <= 1'b0;
          state_q <= S_CS_LEAD;
        end
        S_CS_LEAD: if (tmr_zero) state_q <= S_LOAD;
        S_LOAD:    state_q <= S_XFER;
        S_XFER: if (byte_done) begin
          if (phase_q == PH_HDR) begin
            if (cnt_q == 8'd0) hdr0_q <= rx_byte;
            if (cnt_q == 8'd1) hdr1_q <= rx_byte;
            if (cnt_q == 8'(HDR_BYTES - 1)) begin
              irq_oe_q <= 1'b0;
              irq_do_q <= 1'b0;
            end
          end
          if (nx_trail) begin
            status_q <= nx_status;
            state_q  <= S_CS_TRAIL;
          end else begin
            phase_q <= nx_phase;
            cnt_q   <= nx_cnt;
            state_q <= S_LOAD;
          end
        end
        S_CS_TRAIL: if (tmr_zero) begin
          cs_n_q  <= 1'b1;
          state_q <= S_DONE;
        end
        S_DONE: begin
          mask_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  sgw_byte_shift #(.DIV(CLK_DIV)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .tx_i   (tx_byte),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .rx_o   (rx_byte),
    .done_o (byte_done)
  );

  sgw_wait_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign a_idx_o    = cnt_q;
  assign b_idx_o    = cnt_q;
  assign cs_no      = cs_n_q;
  assign irq_oe_o   = irq_oe_q;
  assign irq_do_o   = irq_do_q;
  assign irq_mask_o = mask_q;
  assign done_o     = done_q;
  assign status_o   = status_q;
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       a_rd_o,
  input logic       b_rd_o,
  input logic       sclk_o,
  input logic       cs_no,
  input logic       irq_oe_o,
  input logic       irq_do_o,
  input logic       irq_mask_o,
  input logic       done_o,
  input logic [1:0] status_o
);
  AST_SCLK_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no); // R11
  AST_MASK_COVERS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> irq_mask_o); // R9
  AST_IRQ_DRIVES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o |-> irq_do_o); // R6
  AST_IRQ_BEFORE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_oe_o) |-> cs_no); // R6
  AST_IRQ_FREE_IN_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_rd_o || b_rd_o) |-> !irq_oe_o); // R7
  AST_ONE_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_rd_o && b_rd_o)); // R4
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !irq_mask_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o != 2'b11)); // R8
endmodule

bind spi_gated_writer sgw_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .a_rd_o     (a_rd_o),
  .b_rd_o     (b_rd_o),
  .sclk_o     (sclk_o),
  .cs_no      (cs_no),
  .irq_oe_o   (irq_oe_o),
  .irq_do_o   (irq_do_o),
  .irq_mask_o (irq_mask_o),
  .done_o     (done_o),
  .status_o   (status_o)
);

// File: tb/spi_gated_writer_tb.sv
module spi_gated_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int KHZ        = 1000;
  localparam int WAIT_US    = 112;
  localparam int WAIT_CYC   = (KHZ * WAIT_US + 999) / 1000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, irq_fix_i = 1'b0;
  logic [7:0] len_a_i = '0, len_b_i = '0;
  logic a_rd_o, b_rd_o, sclk_o, mosi_o, cs_no, irq_oe_o, irq_do_o, irq_mask_o, done_o;
  logic [7:0] a_idx_o, b_idx_o, a_data_i, b_data_i;
  logic miso_i = 1'b0;
  logic [1:0] status_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign a_data_i = 8'hA0 ^ a_idx_o;
  assign b_data_i = 8'h50 + b_idx_o;

  spi_gated_writer #(.CLK_KHZ(KHZ), .MIN_WAIT_US(WAIT_US), .CLK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .irq_fix_i(irq_fix_i),
    .len_a_i(len_a_i), .len_b_i(len_b_i),
    .a_rd_o(a_rd_o), .a_idx_o(a_idx_o), .a_data_i(a_data_i),
    .b_rd_o(b_rd_o), .b_idx_o(b_idx_o), .b_data_i(b_data_i),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_no(cs_no),
    .irq_oe_o(irq_oe_o), .irq_do_o(irq_do_o), .irq_mask_o(irq_mask_o),
    .done_o(done_o), .status_o(status_o)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input int act, input int lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected>=%0d", req, what, act, lim);
    end
  endtask

  // Peripheral model
  logic [7:0] resp [5];
  logic [7:0] mlog [600];
  logic [7:0] mosi_sh;
  int nbytes, bitn, kbit, stray;

  always @(negedge cs_no) begin
    kbit = 0; bitn = 0;
    miso_i = resp[0][7];
  end
  always @(posedge sclk_o) begin
    if (cs_no) stray++;
    else begin
      mosi_sh = {mosi_sh[6:0], mosi_o};
      bitn++;
      if (bitn == 8) begin
        mlog[nbytes] = mosi_sh;
        nbytes++;
        bitn = 0;
      end
    end
  end
  always @(negedge sclk_o) if (!cs_no) begin
    kbit++;
    miso_i = (kbit / 8 < 5) ? resp[kbit/8][7 - kbit%8] : 1'b0;
  end

  // Cycle-stamped edge monitor
  int cyc = 0;
  int oe_rise, oe_fall, cs_fall, cs_rise, first_rise, last_fall, rises, rises_at_oe_fall;
  int cs_falls, dones, a_cnt, b_cnt, idx_err, order_err, mask_gap, oe_seen;
  logic p_oe = 0, p_cs = 1, p_sclk = 0;

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (irq_oe_o && !p_oe) begin oe_rise = cyc; oe_seen++; end
    if (!irq_oe_o && p_oe) begin oe_fall = cyc; rises_at_oe_fall = rises; end
    if (!cs_no && p_cs) begin cs_fall = cyc; cs_falls++; end
    if (cs_no && !p_cs) cs_rise = cyc;
    if (sclk_o && !p_sclk) begin if (rises == 0) first_rise = cyc; rises++; end
    if (!sclk_o && p_sclk) last_fall = cyc;
    if (done_o) dones++;
    if (!cs_no && !irq_mask_o) mask_gap++;
    if (a_rd_o) begin
      if (a_idx_o != 8'(a_cnt)) idx_err++;
      if (b_cnt != 0) order_err++;
      a_cnt++;
    end
    if (b_rd_o) begin
      if (b_idx_o != 8'(b_cnt)) idx_err++;
      b_cnt++;
    end
    p_oe = irq_oe_o; p_cs = cs_no; p_sclk = sclk_o;
  end

  task automatic clear_log();
    nbytes = 0; stray = 0; rises = 0; cs_falls = 0; dones = 0;
    a_cnt = 0; b_cnt = 0; idx_err = 0; order_err = 0; mask_gap = 0; oe_seen = 0;
    rises_at_oe_fall = -1; oe_rise = 0; oe_fall = 0;
  endtask

  task automatic run_txn(input string tag, input bit fix, input int la, input int lb,
                         input logic [7:0] h0, input logic [7:0] h1,
                         input int exp_st, input bit poke);
    int t;
    int npay;
    resp[0] = h0; resp[1] = h1; resp[2] = 0; resp[3] = 0; resp[4] = 0;
    clear_log();
    @(negedge clk);
    irq_fix_i = fix; len_a_i = 8'(la); len_b_i = 8'(lb); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      irq_fix_i = 1'b1; len_a_i = 8'd0; len_b_i = 8'd0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (!done_o && t < 20000) begin @(negedge clk); t++; end
    chk({tag, " R8"}, "done seen", int'(done_o), 1);
    chk({tag, " R8"}, "status", int'(status_o), exp_st);
    chk({tag, " R8"}, "cs released at done", int'(cs_no), 1);
    chk({tag, " R9"}, "mask low at done", int'(irq_mask_o), 0);
    chk({tag, " R9"}, "mask gaps while cs low", mask_gap, 0);
    @(negedge clk);
    chk({tag, " R8"}, "done one cycle", int'(done_o), 0);
    repeat (12) @(negedge clk);
    chk({tag, " R10"}, "cs windows", cs_falls, 1);
    chk({tag, " R10"}, "done pulses", dones, 1);
    npay = (exp_st == 0) ? la + lb : 0;
    chk({tag, " R1"}, "bytes clocked", nbytes, 5 + npay);
    chk({tag, " R1"}, "header cmd", int'(mlog[0]), 8'h0A);
    for (int i = 1; i < 5; i++) chk({tag, " R1"}, "header pad", int'(mlog[i]), 0);
    chk({tag, " R4"}, "fetch A count", a_cnt, (exp_st == 0) ? la : 0);
    chk({tag, " R4"}, "fetch B count", b_cnt, (exp_st == 0) ? lb : 0);
    chk({tag, " R4"}, "fetch order/index errors", idx_err + order_err, 0);
    if (exp_st == 0) begin
      for (int i = 0; i < la; i++)
        chk({tag, " R4"}, "A byte", int'(mlog[5+i]), int'(8'hA0 ^ 8'(i)));
      for (int i = 0; i < lb; i++)
        chk({tag, " R4"}, "B byte", int'(mlog[5+la+i]), int'(8'h50 + 8'(i)));
    end
    chk({tag, " R11"}, "sclk edges with cs high", stray, 0);
    chk_ge({tag, " R11"}, "cs lead", first_rise - cs_fall, DIV);
    chk_ge({tag, " R11"}, "cs trail", cs_rise - last_fall, DIV);
    chk({tag, " R7"}, "irq line driven", oe_seen, fix ? 1 : 0);
    if (fix) begin
      chk_ge({tag, " R6"}, "wait before cs", cs_fall - oe_rise, WAIT_CYC);
      chk({tag, " R7"}, "sclk rises at irq release", rises_at_oe_fall, 40);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset cs", int'(cs_no), 1);
    chk("R11", "reset sclk", int'(sclk_o), 0);
    chk("R7", "reset irq oe", int'(irq_oe_o), 0);
    chk("R9", "reset mask", int'(irq_mask_o), 0);
    chk("R8", "reset done", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    run_txn("ok_exact_space",  1'b0, 3,   2,   8'h02, 8'd5,   0, 1'b0); // R3 boundary
    run_txn("not_ready",       1'b0, 2,   2,   8'hAA, 8'd50,  1, 1'b0); // R2
    run_txn("no_space",        1'b0, 4,   3,   8'h02, 8'd6,   2, 1'b0); // R3
    run_txn("sum_no_wrap",     1'b0, 200, 100, 8'h02, 8'd255, 2, 1'b0); // R3
    run_txn("fix_skip_b",      1'b1, 2,   0,   8'h02, 8'd200, 0, 1'b0); // R5 R6 R7
    run_txn("skip_a",          1'b0, 0,   3,   8'h02, 8'd3,   0, 1'b0); // R5
    run_txn("fix_empty",       1'b1, 0,   0,   8'h02, 8'd0,   0, 1'b0); // R5 R6
    run_txn("fix_not_ready",   1'b1, 1,   1,   8'h03, 8'd9,   1, 1'b0); // R2 R7
    run_txn("busy_start",      1'b0, 5,   4,   8'h02, 8'd20,  0, 1'b1); // R10
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule